// File: doc/BRIEF.md
# Ten-Bit Match Timer with Step Registers

A free-running up counter (10 bits by default) advances once per tick. The tick comes from one of three places: the clock divided by two (the reset choice), the clock divided by sixteen, or a single-cycle enable supplied from outside. The counter wraps from its top value to zero and never stops.

Two compare channels watch the counter. Each channel keeps a compare value and an increment. When the counter steps onto the compare value, the channel does four things:

- It raises a one-cycle match pulse.
- It sets a sticky status flag, which can drive the interrupt line.
- It adds its increment to the compare value, wrapping modulo the counter range, so that events repeat every N counts.
- It can act as a load strobe that copies a staged byte into the output port register on exactly that clock edge.

Software reaches the block through a small write port. A status-clear pulse empties the flags.

Top module: `match_step_timer`

## Requirements
- R1: The counter reads 0 after reset and changes only by +1 per tick, wrapping from 1023 to 0.
- R2: Tick source is set by writing address 0, bits [1:0]. Code 0 (the reset value) advances the counter every 2 clocks. Code 1 advances it every 16 clocks. Codes 2 and 3 advance it on each clock edge at which `ext_tick_i` is high.
- R3: `match_o[i]` is high for exactly the clock cycle in which `count_o` first shows a new value equal to channel i's compare value. Compare values are written at addresses 1 and 2, and both are 0 after reset.
- R4: On a match, channel i's compare value becomes the old compare value plus channel i's increment, modulo 1024. Increments are written at addresses 3 and 4, and both are 0 after reset.
- R5: With an increment of 0, the compare value is left unchanged, so the channel matches once every 1024 ticks.
- R6: `status_o[i]` is set by a match on channel i. A high `rd_stat_i` clears all flags at the next edge. A match at that same edge keeps its flag set.
- R7: `irq_o` is high when any flag in `status_o` is set whose enable bit is also set. The enable bits are written at address 5, with bit i for channel i, and they clear at reset.
- R8: The staged byte is written at address 6, bits [7:0]. The load select is written at address 7, where bit i lets channel i's match load the port. At a match of a selected channel, `port_o` takes the staged byte held before that edge, and `load_strobe_o` is high for that cycle.
- R9: `port_o` keeps its value in every cycle in which `load_strobe_o` is low.
- R10: A write to a compare value at the same edge as that channel's match wins over the automatic reload. The pulse for the current match is still produced.
- R11: During reset, `count_o`, `match_o`, `status_o`, `irq_o`, `load_strobe_o` and `port_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_n_i | input | 1 | active-low synchronous reset |
| ext_tick_i | input | 1 | external single-cycle tick enable |
| wr_en_i | input | 1 | register write strobe |
| wr_addr_i | input | 3 | register address |
| wr_data_i | input | 10 | register write data |
| rd_stat_i | input | 1 | status read, clears flags |
| count_o | output | 10 | counter value |
| match_o | output | 2 | per-channel match pulse |
| status_o | output | 2 | sticky match flags |
| irq_o | output | 1 | interrupt request |
| load_strobe_o | output | 1 | port load pulse |
| port_o | output | 8 | output port register |

## Verification
The bench keeps its own model of both compare values and walks each increment from 0 to 17, plus 511, 512 and 1023, with every increment running over a full counter wrap. This separates correct modulo reload from truncated or stuck reload. The sweep runs under each tick source and with sparse, periodic and continuous external tick patterns, and it measures the gaps between counter changes, which exposes a wrong divider or a mis-decoded select code. Targeted cycles then place a compare-value write and a status clear on the same edge as a match, to check which action takes priority.

// File: rtl/mst_pkg.sv
`timescale 1ns/1ps
package mst_pkg;
   localparam int ADR_W = 3;

   typedef enum logic [1:0] {
      SRC_HALF      = 2'd0,
      SRC_SIXTEENTH = 2'd1,
      SRC_EXT       = 2'd2,
      SRC_EXT_ALT   = 2'd3
   } src_e;

   localparam int ADR_SRC        = 0;
   localparam int ADR_MATCH_BASE = 1;
   localparam int ADR_STEP_BASE  = 3;
   localparam int ADR_IEN        = 5;
   localparam int ADR_STAGE      = 6;
   localparam int ADR_LDSEL      = 7;
endpackage

// File: rtl/mst_tick_gen.sv
`timescale 1ns/1ps
module mst_tick_gen #(
   parameter int FAST_DIV = 2,
   parameter int SLOW_DIV = 16
) (
   input  logic       clk_i,
   input  logic       rst_n_i,
   input  logic [1:0] src_i,
   input  logic       ext_tick_i,
   output logic       tick_o
);
   import mst_pkg::*;
   localparam int PRE_W  = $clog2(SLOW_DIV);
   localparam int FAST_W = $clog2(FAST_DIV);

   logic [PRE_W-1:0] pre_q;
   logic             fast_tick;
   logic             slow_tick;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) pre_q <= '0;
      else          pre_q <= pre_q + 1'b1;
   end

   assign fast_tick = &pre_q[FAST_W-1:0];
   assign slow_tick = &pre_q;

   always_comb begin
      case (src_e'(src_i))
         SRC_HALF:      tick_o = fast_tick;
         SRC_SIXTEENTH: tick_o = slow_tick;
         default:       tick_o = ext_tick_i;
      endcase
   end
endmodule

// File: rtl/mst_match_chan.sv
`timescale 1ns/1ps
module mst_match_chan #(
   parameter int CNT_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] cnt_nxt_i,
   input  logic             wr_match_i,
   input  logic             wr_step_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic             clr_i,
   output logic             hit_o,
   output logic             pulse_o,
   output logic             stat_o,
   output logic [CNT_W-1:0] match_o,
   output logic [CNT_W-1:0] step_o
);
   logic [CNT_W-1:0] match_q;
   logic [CNT_W-1:0] step_q;
   logic             pulse_q;
   logic             stat_q;
   logic             reload;

   assign hit_o  = tick_i && (cnt_nxt_i == match_q);
   assign reload = hit_o && (step_q != '0);

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         match_q <= '0;
         step_q  <= '0;
         pulse_q <= 1'b0;
         stat_q  <= 1'b0;
      end else begin
         pulse_q <= hit_o;
         stat_q  <= hit_o | (stat_q & ~clr_i);
         if (wr_match_i)  match_q <= wr_data_i;
         else if (reload) match_q <= match_q + step_q;
         if (wr_step_i)   step_q  <= wr_data_i;
      end
   end

   assign pulse_o = pulse_q;
   assign stat_o  = stat_q;
   assign match_o = match_q;
   assign step_o  = step_q;
endmodule

// File: rtl/mst_port_stage.sv
`timescale 1ns/1ps
module mst_port_stage #(
   parameter int PORT_W = 8,
   parameter int NUM_CH = 2
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              wr_stage_i,
   input  logic              wr_sel_i,
   input  logic [PORT_W-1:0] wr_data_i,
   input  logic [NUM_CH-1:0] hit_i,
   output logic [PORT_W-1:0] port_o,
   output logic              strobe_o
);
   logic [PORT_W-1:0] stage_q;
   logic [PORT_W-1:0] port_q;
   logic [NUM_CH-1:0] sel_q;
   logic              strobe_q;
   logic              load;

   assign load = |(hit_i & sel_q);

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         stage_q  <= '0;
         port_q   <= '0;
         sel_q    <= '0;
         strobe_q <= 1'b0;
      end else begin
         strobe_q <= load;
         if (load)       port_q  <= stage_q;
         if (wr_stage_i) stage_q <= wr_data_i;
         if (wr_sel_i)   sel_q   <= wr_data_i[NUM_CH-1:0];
      end
   end

   assign port_o   = port_q;
   assign strobe_o = strobe_q;
endmodule

// File: rtl/match_step_timer.sv
`timescale 1ns/1ps
module match_step_timer #(
   parameter int CNT_W    = 10,
   parameter int NUM_CH   = 2,
   parameter int PORT_W   = 8,
   parameter int FAST_DIV = 2,
   parameter int SLOW_DIV = 16
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              ext_tick_i,
   input  logic              wr_en_i,
   input  logic [2:0]        wr_addr_i,
   input  logic [CNT_W-1:0]  wr_data_i,
   input  logic              rd_stat_i,
   output logic [CNT_W-1:0]  count_o,
   output logic [NUM_CH-1:0] match_o,
   output logic [NUM_CH-1:0] status_o,
   output logic              irq_o,
   output logic              load_strobe_o,
   output logic [PORT_W-1:0] port_o
);
   import mst_pkg::*;

   if (CNT_W < 4 || CNT_W > 16) begin : g_bad_cnt_w
      $error("CNT_W must lie in 4..16");
   end
   if (NUM_CH < 1 || NUM_CH > 2) begin : g_bad_num_ch
      $error("NUM_CH must be 1 or 2");
   end
   if (PORT_W < 1 || PORT_W > CNT_W) begin : g_bad_port_w
      $error("PORT_W must lie in 1..CNT_W");
   end
   if (FAST_DIV < 2 || (FAST_DIV & (FAST_DIV - 1)) != 0) begin : g_bad_fast
      $error("FAST_DIV must be a power of two, at least 2");
   end
   if (SLOW_DIV <= FAST_DIV || (SLOW_DIV & (SLOW_DIV - 1)) != 0) begin : g_bad_slow
      $error("SLOW_DIV must be a power of two above FAST_DIV");
   end

   src_e                          src_q;
   logic [NUM_CH-1:0]             ien_q;
   logic [CNT_W-1:0]              cnt_q;
   logic [CNT_W-1:0]              cnt_nxt;
   logic                          tick;
   logic [NUM_CH-1:0]             hit;
   logic [NUM_CH-1:0]             pulse;
   logic [NUM_CH-1:0]             stat;
   logic [NUM_CH-1:0][CNT_W-1:0]  match_val;
   logic [NUM_CH-1:0][CNT_W-1:0]  step_val;
   logic                          wr_src;
   logic                          wr_ien;
   logic                          wr_stage;
   logic                          wr_sel;

   assign wr_src   = wr_en_i && (wr_addr_i == ADR_W'(ADR_SRC));
   assign wr_ien   = wr_en_i && (wr_addr_i == ADR_W'(ADR_IEN));
   assign wr_stage = wr_en_i && (wr_addr_i == ADR_W'(ADR_STAGE));
   assign wr_sel   = wr_en_i && (wr_addr_i == ADR_W'(ADR_LDSEL));

   mst_tick_gen #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_tick (
      .clk_i     (clk_i),
      .rst_n_i   (rst_n_i),
      .src_i     (src_q),
      .ext_tick_i(ext_tick_i),
      .tick_o    (tick)
   );

   assign cnt_nxt = tick ? cnt_q + 1'b1 : cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         cnt_q <= '0;
         src_q <= SRC_HALF;
         ien_q <= '0;
      end else begin
         cnt_q <= cnt_nxt;
         if (wr_src) src_q <= src_e'(wr_data_i[1:0]);
         if (wr_ien) ien_q <= wr_data_i[NUM_CH-1:0];
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic wr_m;
      logic wr_s;
      assign wr_m = wr_en_i && (wr_addr_i == ADR_W'(ADR_MATCH_BASE + c));
      assign wr_s = wr_en_i && (wr_addr_i == ADR_W'(ADR_STEP_BASE + c));
      mst_match_chan #(.CNT_W(CNT_W)) u_chan (
         .clk_i     (clk_i),
         .rst_n_i   (rst_n_i),
         .tick_i    (tick),
         .cnt_nxt_i (cnt_nxt),
         .wr_match_i(wr_m),
         .wr_step_i (wr_s),
         .wr_data_i (wr_data_i),
         .clr_i     (rd_stat_i),
         .hit_o     (hit[c]),
         .pulse_o   (pulse[c]),
         .stat_o    (stat[c]),
         .match_o   (match_val[c]),
         .step_o    (step_val[c])
      );
   end

   mst_port_stage #(.PORT_W(PORT_W), .NUM_CH(NUM_CH)) u_port (
      .clk_i     (clk_i),
      .rst_n_i   (rst_n_i),
      .wr_stage_i(wr_stage),
      .wr_sel_i  (wr_sel),
      .wr_data_i (wr_data_i[PORT_W-1:0]),
      .hit_i     (hit),
      .port_o    (port_o),
      .strobe_o  (load_strobe_o)
   );

   assign count_o  = cnt_q;
   assign match_o  = pulse;
   assign status_o = stat;
   assign irq_o    = |(stat & ien_q);
endmodule

// File: rtl/mst_checker.sv
`timescale 1ns/1ps
module mst_checker #(
   parameter int CNT_W  = 10,
   parameter int NUM_CH = 2,
   parameter int PORT_W = 8
) (
   input logic                         clk_i,
   input logic                         rst_n_i,
   input logic                         wr_en_i,
   input logic [2:0]                   wr_addr_i,
   input logic [CNT_W-1:0]             count_o,
   input logic [NUM_CH-1:0]            match_o,
   input logic [NUM_CH-1:0]            status_o,
   input logic                         irq_o,
   input logic                         load_strobe_o,
   input logic [PORT_W-1:0]            port_o,
   input logic [NUM_CH-1:0][CNT_W-1:0] match_val,
   input logic [NUM_CH-1:0][CNT_W-1:0] step_val
);
   assert_count_step_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      1'b1 |=> (count_o == $past(count_o)) || (count_o == CNT_W'($past(count_o) + 1'b1)));

   assert_port_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !load_strobe_o |-> $stable(port_o));

   assert_strobe_match_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      load_strobe_o |-> (match_o != '0));

   assert_irq_status_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      irq_o |-> (status_o != '0));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      assert_match_value_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
         match_o[c] |-> (count_o == $past(match_val[c])));

      assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
         (match_o[c] && !$past(wr_en_i && (wr_addr_i == 3'(1 + c))))
         |-> (match_val[c] == CNT_W'($past(match_val[c]) + $past(step_val[c]))));

      assert_status_set_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
         match_o[c] |-> status_o[c]);
   end
endmodule

bind match_step_timer mst_checker #(
   .CNT_W(CNT_W), .NUM_CH(NUM_CH), .PORT_W(PORT_W)
) chk_i (
   .clk_i        (clk_i),
   .rst_n_i      (rst_n_i),
   .wr_en_i      (wr_en_i),
   .wr_addr_i    (wr_addr_i),
   .count_o      (count_o),
   .match_o      (match_o),
   .status_o     (status_o),
   .irq_o        (irq_o),
   .load_strobe_o(load_strobe_o),
   .port_o       (port_o),
   .match_val    (match_val),
   .step_val     (step_val)
);

// File: tb/match_step_timer_tb_top.sv
`timescale 1ns/1ps
module match_step_timer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [9:0] wr_data = '0;
   logic       rd_stat = 1'b0;
   logic [9:0] count;
   logic [1:0] match;
   logic [1:0] status;
   logic       irq;
   logic       strobe;
   logic [7:0] port;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   match_step_timer dut_i (
      .clk_i(clk), .rst_n_i(rst_n), .ext_tick_i(ext_tick),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_stat_i(rd_stat), .count_o(count), .match_o(match),
      .status_o(status), .irq_o(irq), .load_strobe_o(strobe), .port_o(port)
   );

   // bench model state
   bit         mon_on = 1'b0;
   logic [9:0] prev_cnt = '0;
   logic [9:0] exp_m [2];
   logic [9:0] exp_s [2];
   logic [1:0] exp_stat = '0;
   logic [1:0] exp_ien = '0;
   logic [1:0] exp_sel = '0;
   logic [7:0] exp_stage = '0;
   logic [7:0] exp_port = '0;
   logic [1:0] exp_src = '0;
   int gap = 0;
   int settled = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (mon_on) begin
         logic       p_wr, p_rd, p_ext, changed, load;
         logic [2:0] p_a;
         logic [9:0] p_d, c, nm;
         logic [1:0] hit;
         p_wr = wr_en; p_a = wr_addr; p_d = wr_data; p_rd = rd_stat; p_ext = ext_tick;
         #2;
         c = count;
         changed = (c != prev_cnt);
         chk(!changed || c == 10'(prev_cnt + 1), "R1 count step", c, 10'(prev_cnt + 1));
         if (exp_src >= 2) begin
            chk(changed == p_ext, "R2 external tick", changed, p_ext);
         end else begin
            gap++;
            if (changed) begin
               if (settled >= 1)
                  chk(gap == (exp_src == 0 ? 2 : 16), "R2 divider gap", gap, exp_src == 0 ? 2 : 16);
               settled++;
               gap = 0;
            end
         end
         for (int i = 0; i < 2; i++) hit[i] = changed && (c == exp_m[i]);
         chk(match == hit, (exp_s[0] == 0) ? "R3 R5 match pulse" : "R3 R4 match pulse", match, hit);
         load = |(hit & exp_sel);
         if (load) exp_port = exp_stage;
         chk(strobe == load, "R8 load strobe", strobe, load);
         chk(port == exp_port, "R8 R9 port value", port, exp_port);
         exp_stat = hit | (exp_stat & ~{2{p_rd}});
         for (int i = 0; i < 2; i++) begin
            if (p_wr && p_a == 3'(1 + i)) exp_m[i] = p_d;
            else if (hit[i] && exp_s[i] != 0) begin
               nm = 10'(exp_m[i] + exp_s[i]);
               exp_m[i] = nm;
            end
            if (p_wr && p_a == 3'(3 + i)) exp_s[i] = p_d;
         end
         if (p_wr && p_a == 3'd5) exp_ien = p_d[1:0];
         if (p_wr && p_a == 3'd6) exp_stage = p_d[7:0];
         if (p_wr && p_a == 3'd7) exp_sel = p_d[1:0];
         if (p_wr && p_a == 3'd0) begin exp_src = p_d[1:0]; settled = 0; gap = 0; end
         chk(status == exp_stat, "R6 status flags", status, exp_stat);
         chk(irq == |(exp_stat & exp_ien), "R7 interrupt", irq, |(exp_stat & exp_ien));
         prev_cnt = c;
      end
   end

   task automatic wr(input logic [2:0] a, input logic [9:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run(input int n, input int pat);
      for (int i = 0; i < n; i++) begin
         case (pat)
            0: ext_tick = 1'b0;
            1: ext_tick = 1'b1;
            2: ext_tick = (i % 3 == 0);
            default: ext_tick = ((i * 5) % 7 < 3);
         endcase
         rd_stat = (i % 97 == 50);
         @(negedge clk);
      end
      ext_tick = 1'b0;
      rd_stat = 1'b0;
   endtask

   initial begin
      logic [9:0] nv;
      int steps [21];
      exp_m[0] = '0; exp_m[1] = '0; exp_s[0] = '0; exp_s[1] = '0;
      repeat (5) @(negedge clk);
      // R11: reset values
      chk(count == 0, "R11 reset count", count, 0);
      chk(match == 0, "R11 reset match", match, 0);
      chk(status == 0 && irq == 0, "R11 reset status/irq", {status, irq}, 0);
      chk(port == 0 && strobe == 0, "R11 reset port", port, 0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      @(negedge clk);
      // default source, ch0 reloads by 7 and loads port
      wr(3'd1, 10'd5); wr(3'd3, 10'd7); wr(3'd2, 10'd3);
      wr(3'd5, 10'd1); wr(3'd6, 10'h0A5); wr(3'd7, 10'd1);
      run(2200, 0);
      // divide by 16
      wr(3'd0, 10'd1); wr(3'd5, 10'd3); wr(3'd7, 10'd3); wr(3'd6, 10'h03C);
      run(16600, 0);
      // external sources
      wr(3'd0, 10'd2); run(3000, 2);
      wr(3'd0, 10'd3); run(2500, 3);
      // increment sweep with continuous ticks
      for (int s = 0; s < 18; s++) steps[s] = s;
      steps[18] = 511; steps[19] = 512; steps[20] = 1023;
      for (int k = 0; k < 21; k++) begin
         wr(3'd3, 10'(steps[k])); wr(3'd4, 10'(1023 - steps[k]));
         wr(3'd5, 10'(k % 4)); wr(3'd7, 10'((k + 1) % 4)); wr(3'd6, 10'(k * 11));
         run(1100, 1);
      end
      // R10: compare write at the same edge as a match
      wr(3'd3, 10'd9); wr(3'd4, 10'd13);
      for (int i = 0; i < 2100; i++) begin
         if (10'(count + 1) == exp_m[0]) break;
         ext_tick = 1'b1; @(negedge clk);
      end
      nv = 10'(exp_m[0] + 100);
      ext_tick = 1'b1; wr(3'd1, nv);
      chk(match[0] == 1'b1, "R10 pulse kept on collision", match[0], 1);
      for (int i = 0; i < 1100; i++) begin
         @(negedge clk);
         if (match[0]) break;
      end
      chk(match[0] && count == nv, "R10 written value wins", count, nv);
      // R6: clear at the same edge as a match keeps the flag
      for (int i = 0; i < 2100; i++) begin
         if (10'(count + 1) == exp_m[1]) break;
         @(negedge clk);
      end
      rd_stat = 1'b1; @(negedge clk);
      chk(status[1] == 1'b1, "R6 match beats clear", status[1], 1);
      ext_tick = 1'b0; @(negedge clk);
      rd_stat = 1'b0;
      chk(status == 2'b00, "R6 clear empties flags", status, 0);
      @(negedge clk);
      // back to the reset divider
      wr(3'd0, 10'd0); run(300, 0);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule